// File: doc/BRIEF.md
# Alarm Time Store and Match Detector

This block keeps an alarm time (hour and minute) for a time-of-day clock. The alarm is adjusted with the same hour-select, minute-select and step controls that the clock itself uses. They act on the alarm only while the block's own adjust enable is high. Each step advances the selected field by one and wraps at the end of its range. The hour range depends on whether the clock runs in 12-hour or 24-hour form.

Once a second the clock counter presents its hour, minute and second, together with a one-cycle tick. When the tick arrives at second zero and the presented hour and minute equal the stored alarm, the block raises a pulse one system clock long. The clock's hour is already in the active format, so the stored hour is compared as it is. The stored alarm stays visible on two outputs for a display.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset the stored alarm is 0 hours and 0 minutes, and the alarm pulse is low.
- R2: While the adjust enable is low, steps do not change the stored hour or minute.
- R3: While adjusting, a step changes the hour when the hour select is high. If both selects are high, the hour still changes and the minute does not.
- R4: While adjusting with only the minute select high, a step advances the minute. The minute goes from 59 back to 0.
- R5: When the format input is 1 (24-hour form), a step advances the hour, and the hour goes from 23 back to 0.
- R6: When the format input is 0 (12-hour form), the hour goes from 11 back to 0. A stored hour above 11 also steps to 0.
- R7: A step occurs on the rising edge of the step input. Holding the input high gives exactly one step, and the change appears one clock after the rise.
- R8: If the tick is high, the presented second is 0, and the presented hour and minute equal the stored alarm, the pulse is high in the next cycle. The pulse lasts one cycle for a one-cycle tick.
- R9: No pulse follows a cycle in which the tick is low, the second is not 0, or the hour or minute differs from the stored alarm.
- R10: No pulse follows a cycle in which the adjust enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second strobe, one cycle wide |
| adj_en_i | input | 1 | Enables alarm adjustment |
| sel_hour_i | input | 1 | Selects the hour field for stepping |
| sel_min_i | input | 1 | Selects the minute field for stepping |
| step_i | input | 1 | Step button level, rising-edge sensitive |
| fmt24_i | input | 1 | 1 = 24-hour range, 0 = 12-hour range |
| cur_hour_i | input | 5 | Present clock hour |
| cur_min_i | input | 6 | Present clock minute |
| cur_sec_i | input | 6 | Present clock second |
| alm_hour_o | output | 5 | Stored alarm hour |
| alm_min_o | output | 6 | Stored alarm minute |
| alarm_pulse_o | output | 1 | One-cycle alarm match pulse |

## Verification
The match logic is swept over every hour and minute of a day with the second at zero. This separates exact matches from times that differ only in the hour or only in the minute. All 60 seconds are also swept at the matching minute, which shows that only second zero fires. Two further cases, a match with no tick and a match during adjustment, show that each gating condition suppresses the pulse by itself. Adjustment is stepped across every hour of both ranges and every minute, including a switch of format while the stored hour lies outside the 12-hour range. A held step input checks that holding the button is not taken as repeated presses.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
    localparam int HOUR_W      = 5;
    localparam int MIN_W       = 6;
    localparam int HOURS_LONG  = 24;
    localparam int HOURS_SHORT = 12;
    localparam int MINS        = 60;

    localparam logic [HOUR_W-1:0] HOUR_TOP_LONG  = HOUR_W'(HOURS_LONG - 1);
    localparam logic [HOUR_W-1:0] HOUR_TOP_SHORT = HOUR_W'(HOURS_SHORT - 1);
    localparam logic [MIN_W-1:0]  MIN_TOP        = MIN_W'(MINS - 1);

    typedef struct packed {
        logic pulse;
    } match_st_t;

    typedef struct packed {
        logic prev;
    } edge_st_t;
endpackage

// File: rtl/alarm_step_edge.sv
module alarm_step_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    import alarm_pkg::*;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_i;
        rise_o    = lvl_i & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/alarm_wrap_field.sv
module alarm_wrap_field #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic [W-1:0] top_i,
    output logic [W-1:0] val_o
);
    typedef struct packed {
        logic [W-1:0] val;
    } fld_t;

    fld_t fld_d, fld_q;

    always_comb begin
        fld_d = fld_q;
        if (inc_i) begin
            // values at or beyond the top (possible after a range change) fold to zero
            if (fld_q.val >= top_i) fld_d.val = '0;
            else                    fld_d.val = fld_q.val + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fld_q <= '0;
        else        fld_q <= fld_d;
    end

    assign val_o = fld_q.val;
endmodule

// File: rtl/alarm_time_cmp.sv
module alarm_time_cmp #(
    parameter int HW = 5,
    parameter int MW = 6
) (
    input  logic          tick_i,
    input  logic          adj_en_i,
    input  logic [HW-1:0] alm_hour_i,
    input  logic [MW-1:0] alm_min_i,
    input  logic [HW-1:0] cur_hour_i,
    input  logic [MW-1:0] cur_min_i,
    input  logic [MW-1:0] cur_sec_i,
    output logic          hit_o
);
    logic same_hour, same_min, sec_zero;

    always_comb begin
        same_hour = (alm_hour_i == cur_hour_i);
        same_min  = (alm_min_i == cur_min_i);
        sec_zero  = (cur_sec_i == '0);
        hit_o     = tick_i & ~adj_en_i & sec_zero & same_hour & same_min;
    end
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       adj_en_i,
    input  logic       sel_hour_i,
    input  logic       sel_min_i,
    input  logic       step_i,
    input  logic       fmt24_i,
    input  logic [4:0] cur_hour_i,
    input  logic [5:0] cur_min_i,
    input  logic [5:0] cur_sec_i,
    output logic [4:0] alm_hour_o,
    output logic [5:0] alm_min_o,
    output logic       alarm_pulse_o
);
    import alarm_pkg::*;

    logic              step_rise;
    logic              hour_inc, min_inc;
    logic [HOUR_W-1:0] hour_top;
    logic              hit;
    match_st_t         m_d, m_q;

    alarm_step_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (step_i),
        .rise_o (step_rise)
    );

    always_comb begin
        hour_top = fmt24_i ? HOUR_TOP_LONG : HOUR_TOP_SHORT;
        hour_inc = adj_en_i & sel_hour_i & step_rise;
        min_inc  = adj_en_i & ~sel_hour_i & sel_min_i & step_rise;
    end

    alarm_wrap_field #(.W(HOUR_W)) u_hour (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (hour_inc),
        .top_i (hour_top),
        .val_o (alm_hour_o)
    );

    alarm_wrap_field #(.W(MIN_W)) u_min (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (min_inc),
        .top_i (MIN_TOP),
        .val_o (alm_min_o)
    );

    alarm_time_cmp #(.HW(HOUR_W), .MW(MIN_W)) u_cmp (
        .tick_i     (tick_i),
        .adj_en_i   (adj_en_i),
        .alm_hour_i (alm_hour_o),
        .alm_min_i  (alm_min_o),
        .cur_hour_i (cur_hour_i),
        .cur_min_i  (cur_min_i),
        .cur_sec_i  (cur_sec_i),
        .hit_o      (hit)
    );

    always_comb begin
        m_d       = m_q;
        m_d.pulse = hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign alarm_pulse_o = m_q.pulse;
endmodule

// File: rtl/alarm_match_unit_chk.sv
module alarm_match_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       adj_en_i,
    input logic       sel_hour_i,
    input logic       sel_min_i,
    input logic       step_i,
    input logic [4:0] cur_hour_i,
    input logic [5:0] cur_min_i,
    input logic [5:0] cur_sec_i,
    input logic [4:0] alm_hour_o,
    input logic [5:0] alm_min_o,
    input logic       alarm_pulse_o
);
    // R2
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adj_en_i |=> ($stable(alm_hour_o) && $stable(alm_min_o)));

    // R4
    min_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alm_min_o <= 6'd59);

    // R5
    hour_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alm_hour_o <= 5'd23);

    // R4
    min_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && adj_en_i && sel_min_i && !sel_hour_i && step_i && !$past(step_i))
        |=> (alm_min_o == (($past(alm_min_o) == 6'd59) ? 6'd0 : $past(alm_min_o) + 6'd1)));

    // R7
    held_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && step_i && $past(step_i)) |=> ($stable(alm_hour_o) && $stable(alm_min_o)));

    // R8
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_pulse_o |-> ($past(tick_i) && ($past(cur_sec_i) == 6'd0)
                           && ($past(cur_hour_i) == $past(alm_hour_o))
                           && ($past(cur_min_i) == $past(alm_min_o))));

    // R10
    quiet_adjust_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adj_en_i |=> !alarm_pulse_o);
endmodule

bind alarm_match_unit alarm_match_unit_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick_i),
    .adj_en_i      (adj_en_i),
    .sel_hour_i    (sel_hour_i),
    .sel_min_i     (sel_min_i),
    .step_i        (step_i),
    .cur_hour_i    (cur_hour_i),
    .cur_min_i     (cur_min_i),
    .cur_sec_i     (cur_sec_i),
    .alm_hour_o    (alm_hour_o),
    .alm_min_o     (alm_min_o),
    .alarm_pulse_o (alarm_pulse_o)
);

// File: tb/alarm_match_unit_tb_top.sv
module alarm_match_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0, adj_en_i = 1'b0, sel_hour_i = 1'b0, sel_min_i = 1'b0;
    logic       step_i = 1'b0, fmt24_i = 1'b1;
    logic [4:0] cur_hour_i = '0;
    logic [5:0] cur_min_i = '0, cur_sec_i = '0;
    logic [4:0] alm_hour_o;
    logic [5:0] alm_min_o;
    logic       alarm_pulse_o;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_h = 0;
    int exp_m = 0;

    always #4 clk = ~clk;

    alarm_match_unit dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .adj_en_i(adj_en_i),
        .sel_hour_i(sel_hour_i), .sel_min_i(sel_min_i), .step_i(step_i),
        .fmt24_i(fmt24_i), .cur_hour_i(cur_hour_i), .cur_min_i(cur_min_i),
        .cur_sec_i(cur_sec_i), .alm_hour_o(alm_hour_o), .alm_min_o(alm_min_o),
        .alarm_pulse_o(alarm_pulse_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_alarm(input string req);
        check(req, int'(alm_hour_o), exp_h);
        check(req, int'(alm_min_o), exp_m);
    endtask

    // one button press; the bench model follows the requirements
    task automatic press();
        int top;
        step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
        top = fmt24_i ? 23 : 11;
        if (adj_en_i && sel_hour_i) exp_h = (exp_h >= top) ? 0 : exp_h + 1;
        else if (adj_en_i && sel_min_i) exp_m = (exp_m == 59) ? 0 : exp_m + 1;
        @(negedge clk);
    endtask

    task automatic probe(input int h, input int m, input int s, input logic tk, input int exp, input string req);
        cur_hour_i = 5'(h);
        cur_min_i  = 6'(m);
        cur_sec_i  = 6'(s);
        tick_i     = tk;
        @(negedge clk);
        check(req, int'(alarm_pulse_o), exp);
        tick_i = 1'b0;
        @(negedge clk);
        if (exp == 1) check("R8 width", int'(alarm_pulse_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", int'(alarm_pulse_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_alarm("R1");

        // R2: steps ignored while adjust is off
        sel_hour_i = 1'b1;
        sel_min_i  = 1'b1;
        press();
        check_alarm("R2");

        // R5: full 24-hour sweep
        adj_en_i  = 1'b1;
        sel_min_i = 1'b0;
        fmt24_i   = 1'b1;
        for (int i = 0; i < 25; i++) begin
            press();
            check_alarm("R5");
        end

        // R6: 12-hour sweep
        fmt24_i = 1'b0;
        for (int i = 0; i < 14; i++) begin
            press();
            check_alarm("R6");
        end

        // R6: out-of-range hour after format change
        fmt24_i = 1'b1;
        while (exp_h != 15) press();
        check_alarm("R6 setup");
        fmt24_i = 1'b0;
        press();
        check_alarm("R6 fold");
        check("R6 fold", int'(alm_hour_o), 0);

        // R3: both selects, hour wins
        fmt24_i   = 1'b1;
        sel_min_i = 1'b1;
        press();
        check_alarm("R3");

        // R4: minute sweep with wrap
        sel_hour_i = 1'b0;
        for (int i = 0; i < 61; i++) begin
            press();
            check_alarm("R4");
        end

        // R7: held step gives one advance
        step_i = 1'b1;
        repeat (6) @(negedge clk);
        exp_m = (exp_m == 59) ? 0 : exp_m + 1;
        check_alarm("R7");
        step_i = 1'b0;
        @(negedge clk);
        check_alarm("R7");

        // program the alarm to 7:45
        while (exp_m != 45) press();
        sel_min_i  = 1'b0;
        sel_hour_i = 1'b1;
        while (exp_h != 7) press();
        check_alarm("R3 setup");

        // R10: a match while adjusting stays silent
        probe(7, 45, 0, 1'b1, 0, "R10");
        adj_en_i   = 1'b0;
        sel_hour_i = 1'b0;

        // R8 / R9: sweep a whole day at second zero
        for (int h = 0; h < 24; h++)
            for (int m = 0; m < 60; m++)
                probe(h, m, 0, 1'b1, (h == 7 && m == 45) ? 1 : 0,
                      (h == 7 && m == 45) ? "R8" : "R9");

        // R9: seconds sweep at the matching minute
        for (int s = 0; s < 60; s++)
            probe(7, 45, s, 1'b1, (s == 0) ? 1 : 0, (s == 0) ? "R8" : "R9 sec");

        // R9: no tick
        probe(7, 45, 0, 1'b0, 0, "R9 tick");

        // R8: 12-hour form compares the same stored hour
        fmt24_i = 1'b0;
        probe(7, 45, 0, 1'b1, 1, "R8 12h");
        check_alarm("R2 hold");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule